// File: doc/BRIEF.md
# Serial Link Grouping and Loopback Router

This block sits between sixteen serial TDM link pin groups and the per-link transmit and receive engines of the core. Every link has a transmit control word and a receive control word. The block registers both words and decodes three things from them: the routing for the link, the drive direction of the link's transmit clock and sync, and whether a high-rate grouped mode is in force.

The links form fixed groups of four consecutive indices. Only the lowest link of each group can run in the grouped high-rate mode. When that link's control word selects the mode, the three other links of its group are shut off. Their output enables drop, and their data, clock and sync outputs toward both the pins and the core are held low.

Each link also has two loopback paths that can be used separately or together. Remote loopback sends the pin-side receive data, clock and sync straight back out on the same link's transmit pins, and the receive engine still sees the pins. Metallic loopback feeds the transmit engine's output into the same link's receive engine in place of the pins. A link only ever loops to itself.

Top module: `lgr_top`

## Requirements
- R1: Both control word buses are sampled on each rising clock edge. A changed word alters the outputs only after the first rising edge at which the new value is present. Before that edge the outputs follow the previous word.
- R2: Links are grouped as indices 4g to 4g+3. The survivor links 0, 4, 8 and 12 are never shut off, whatever their own or their neighbours' words hold.
- R3: A transmit word selects high-rate mode when bits 6:5 = 11, bits 4:3 = 00 and bit 2 = 0. Any other value of those bits does not select it.
- R4: A receive word selects high-rate mode under the same three field conditions and, in addition, bit 10 = 1. Without bit 10 the receive word has no grouping effect.
- R5: When a survivor's transmit or receive word selects high-rate mode, the other three links of its group are shut off. A shut-off link has all three output enables low, its transmit pin outputs low and its core-side receive outputs low.
- R6: A high-rate word written to a non-survivor link has no grouping effect on any link.
- R7: Bit 8 of a live link's transmit word enables remote loopback. The transmit pins carry that link's pin receive data, clock and sync, and the clock and sync output enables are high. The core receive outputs still follow the pins unless metallic loopback is also set.
- R8: Bit 8 of a live link's receive word enables metallic loopback. The core receive data, clock and sync outputs carry that link's core transmit data, clock and sync.
- R9: When both loopback bits are set on one live link, both paths apply at the same time.
- R10: On a live link the data output enable is high. The clock and sync output enables are high when bit 7 (clock/sync drive) or bit 8 of the transmit word is set, and low otherwise. Without remote loopback the transmit pins carry the core transmit data, clock and sync.
- R11: Reset is asynchronous, active low, and its release takes effect at the second rising edge. While reset is in effect both words read as zero: every link is live, there is no loopback, and the clock and sync enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ctrl | input | NUM_LINKS*CW_W | Transmit control words, link n at bits n*CW_W upward |
| rx_ctrl | input | NUM_LINKS*CW_W | Receive control words, same packing |
| pin_rxd | input | NUM_LINKS | Receive data from pins |
| pin_rxclk | input | NUM_LINKS | Receive clock from pins |
| pin_rxsync | input | NUM_LINKS | Receive sync from pins |
| core_txd | input | NUM_LINKS | Transmit data from transmit engines |
| core_txclk | input | NUM_LINKS | Transmit clock from transmit engines |
| core_txsync | input | NUM_LINKS | Transmit sync from transmit engines |
| pin_txd | output | NUM_LINKS | Transmit data toward pins |
| pin_txclk | output | NUM_LINKS | Transmit clock toward pins |
| pin_txsync | output | NUM_LINKS | Transmit sync toward pins |
| pin_txd_oe | output | NUM_LINKS | Output enable of transmit data pins |
| pin_txclk_oe | output | NUM_LINKS | Output enable of transmit clock pins |
| pin_txsync_oe | output | NUM_LINKS | Output enable of transmit sync pins |
| core_rxd | output | NUM_LINKS | Receive data toward receive engines |
| core_rxclk | output | NUM_LINKS | Receive clock toward receive engines |
| core_rxsync | output | NUM_LINKS | Receive sync toward receive engines |

## Verification
The bench targets near-miss control words that differ from the high-rate pattern in one field, and receive words that lack bit 10. A decoder that checked too few bits would shut off neighbours here. It also writes high-rate words into non-survivor links, where a design that grouped by the wrong index would silence the wrong links. Loopback bits are set on shut-off links and on links with both paths active, so the bench can tell whether shut-off wins and whether one loopback wrongly masks the other. Control words are changed between edges and the outputs are sampled before the next edge, which exposes a design that takes a new word one cycle early or one cycle late.

// File: rtl/lgr_pkg.sv
package lgr_pkg;

  // Control word field positions (shared by transmit and receive words)
  localparam int RATE_MSB   = 6;
  localparam int RATE_LSB   = 5;
  localparam int MUXF_MSB   = 4;
  localparam int MUXF_LSB   = 3;
  localparam int FMT_BIT    = 2;
  localparam int CLKDRV_BIT = 7;
  localparam int LOOP_BIT   = 8;
  localparam int CELL_BIT   = 10;

  // Decoded transmit-side settings of one link
  typedef struct packed {
    logic fast;
    logic loop;
    logic clk_drv;
  } tx_lane_t;

  // Decoded receive-side settings of one link
  typedef struct packed {
    logic fast;
    logic loop;
  } rx_lane_t;

endpackage

// File: rtl/lgr_rst_sync.sv
module lgr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/lgr_cfg_regs.sv
module lgr_cfg_regs
  import lgr_pkg::*;
#(
  parameter int NUM_LINKS = 16,
  parameter int CW_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINKS*CW_W-1:0] tx_ctrl,
  input  logic [NUM_LINKS*CW_W-1:0] rx_ctrl,
  output tx_lane_t [NUM_LINKS-1:0]  tx_cfg,
  output rx_lane_t [NUM_LINKS-1:0]  rx_cfg
);

  localparam int TXL_W = $bits(tx_lane_t);
  localparam int RXL_W = $bits(rx_lane_t);

  tx_lane_t [NUM_LINKS-1:0] tx_cfg_d, tx_cfg_q;
  rx_lane_t [NUM_LINKS-1:0] rx_cfg_d, rx_cfg_q;
  logic                     cfg_en;

  // Configuration is taken on every edge; the enable is kept explicit.
  assign cfg_en = 1'b1;

  always_comb begin
    for (int i = 0; i < NUM_LINKS; i++) begin
      logic [CW_W-1:0] tw;
      logic [CW_W-1:0] rw;
      logic            t_pat;
      logic            r_pat;
      tw    = tx_ctrl[i*CW_W +: CW_W];
      rw    = rx_ctrl[i*CW_W +: CW_W];
      t_pat = (tw[RATE_MSB:RATE_LSB] == 2'b11) &&
              (tw[MUXF_MSB:MUXF_LSB] == 2'b00) && !tw[FMT_BIT];
      r_pat = (rw[RATE_MSB:RATE_LSB] == 2'b11) &&
              (rw[MUXF_MSB:MUXF_LSB] == 2'b00) && !rw[FMT_BIT];
      tx_cfg_d[i].fast    = t_pat;
      tx_cfg_d[i].loop    = tw[LOOP_BIT];
      tx_cfg_d[i].clk_drv = tw[CLKDRV_BIT];
      rx_cfg_d[i].fast    = r_pat && rw[CELL_BIT];
      rx_cfg_d[i].loop    = rw[LOOP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cfg_q <= '0;
      rx_cfg_q <= '0;
    end else if (cfg_en) begin
      tx_cfg_q <= tx_cfg_d;
      rx_cfg_q <= rx_cfg_d;
    end
  end

  assign tx_cfg = tx_cfg_q;
  assign rx_cfg = rx_cfg_q;

  // The registered loop bits match the words present one edge earlier
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_chk
    assert_cfg_next_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (tx_cfg_q[i].loop == $past(tx_ctrl[i*CW_W+LOOP_BIT])) &&
                       (rx_cfg_q[i].loop == $past(rx_ctrl[i*CW_W+LOOP_BIT])));
  end

  if (TXL_W != 3 || RXL_W != 2) begin : g_bad_type
    initial $error("lane settings types have unexpected width");
  end

endmodule

// File: rtl/lgr_group_ctl.sv
module lgr_group_ctl
  import lgr_pkg::*;
#(
  parameter int NUM_LINKS  = 16,
  parameter int GROUP_SIZE = 4
) (
  input  tx_lane_t [NUM_LINKS-1:0] tx_cfg,
  input  rx_lane_t [NUM_LINKS-1:0] rx_cfg,
  output logic     [NUM_LINKS-1:0] lane_off
);

  localparam int NUM_GROUPS = NUM_LINKS / GROUP_SIZE;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BASE = g * GROUP_SIZE;
    logic grp_fast;

    // Only the survivor link's words can place a group in high-rate mode
    assign grp_fast = tx_cfg[BASE].fast | rx_cfg[BASE].fast;

    assign lane_off[BASE] = 1'b0;
    for (genvar k = 1; k < GROUP_SIZE; k++) begin : g_mem
      assign lane_off[BASE+k] = grp_fast;
    end
  end

  if (NUM_GROUPS * GROUP_SIZE != NUM_LINKS) begin : g_bad_cfg
    initial $error("NUM_LINKS must be a multiple of GROUP_SIZE");
  end

endmodule

// File: rtl/lgr_lane_path.sv
module lgr_lane_path
  import lgr_pkg::*;
#(
  parameter int NUM_LINKS = 16
) (
  input  tx_lane_t [NUM_LINKS-1:0] tx_cfg,
  input  rx_lane_t [NUM_LINKS-1:0] rx_cfg,
  input  logic     [NUM_LINKS-1:0] lane_off,
  input  logic     [NUM_LINKS-1:0] pin_rxd,
  input  logic     [NUM_LINKS-1:0] pin_rxclk,
  input  logic     [NUM_LINKS-1:0] pin_rxsync,
  input  logic     [NUM_LINKS-1:0] core_txd,
  input  logic     [NUM_LINKS-1:0] core_txclk,
  input  logic     [NUM_LINKS-1:0] core_txsync,
  output logic     [NUM_LINKS-1:0] pin_txd,
  output logic     [NUM_LINKS-1:0] pin_txclk,
  output logic     [NUM_LINKS-1:0] pin_txsync,
  output logic     [NUM_LINKS-1:0] pin_txd_oe,
  output logic     [NUM_LINKS-1:0] pin_txclk_oe,
  output logic     [NUM_LINKS-1:0] pin_txsync_oe,
  output logic     [NUM_LINKS-1:0] core_rxd,
  output logic     [NUM_LINKS-1:0] core_rxclk,
  output logic     [NUM_LINKS-1:0] core_rxsync
);

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane
    logic live;
    logic rem_lb;
    logic met_lb;
    logic cs_drive;

    always_comb begin
      live     = !lane_off[i];
      rem_lb   = tx_cfg[i].loop;
      met_lb   = rx_cfg[i].loop;
      cs_drive = tx_cfg[i].clk_drv | rem_lb;

      // Pin side: remote loopback reflects the receive pins
      pin_txd[i]    = live & (rem_lb ? pin_rxd[i]    : core_txd[i]);
      pin_txclk[i]  = live & (rem_lb ? pin_rxclk[i]  : core_txclk[i]);
      pin_txsync[i] = live & (rem_lb ? pin_rxsync[i] : core_txsync[i]);

      pin_txd_oe[i]    = live;
      pin_txclk_oe[i]  = live & cs_drive;
      pin_txsync_oe[i] = live & cs_drive;

      // Core side: metallic loopback substitutes the transmit engine output
      core_rxd[i]    = live & (met_lb ? core_txd[i]    : pin_rxd[i]);
      core_rxclk[i]  = live & (met_lb ? core_txclk[i]  : pin_rxclk[i]);
      core_rxsync[i] = live & (met_lb ? core_txsync[i] : pin_rxsync[i]);
    end
  end

endmodule

// File: rtl/lgr_top.sv
module lgr_top
  import lgr_pkg::*;
#(
  parameter int NUM_LINKS  = 16,
  parameter int GROUP_SIZE = 4,
  parameter int CW_W       = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINKS*CW_W-1:0] tx_ctrl,
  input  logic [NUM_LINKS*CW_W-1:0] rx_ctrl,
  input  logic [NUM_LINKS-1:0]      pin_rxd,
  input  logic [NUM_LINKS-1:0]      pin_rxclk,
  input  logic [NUM_LINKS-1:0]      pin_rxsync,
  input  logic [NUM_LINKS-1:0]      core_txd,
  input  logic [NUM_LINKS-1:0]      core_txclk,
  input  logic [NUM_LINKS-1:0]      core_txsync,
  output logic [NUM_LINKS-1:0]      pin_txd,
  output logic [NUM_LINKS-1:0]      pin_txclk,
  output logic [NUM_LINKS-1:0]      pin_txsync,
  output logic [NUM_LINKS-1:0]      pin_txd_oe,
  output logic [NUM_LINKS-1:0]      pin_txclk_oe,
  output logic [NUM_LINKS-1:0]      pin_txsync_oe,
  output logic [NUM_LINKS-1:0]      core_rxd,
  output logic [NUM_LINKS-1:0]      core_rxclk,
  output logic [NUM_LINKS-1:0]      core_rxsync
);

  logic                     rst_sync_n;
  tx_lane_t [NUM_LINKS-1:0] tx_cfg;
  rx_lane_t [NUM_LINKS-1:0] rx_cfg;
  logic     [NUM_LINKS-1:0] lane_off;

  lgr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lgr_cfg_regs #(
    .NUM_LINKS (NUM_LINKS),
    .CW_W      (CW_W)
  ) u_cfg_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tx_ctrl (tx_ctrl),
    .rx_ctrl (rx_ctrl),
    .tx_cfg  (tx_cfg),
    .rx_cfg  (rx_cfg)
  );

  lgr_group_ctl #(
    .NUM_LINKS  (NUM_LINKS),
    .GROUP_SIZE (GROUP_SIZE)
  ) u_group_ctl (
    .tx_cfg   (tx_cfg),
    .rx_cfg   (rx_cfg),
    .lane_off (lane_off)
  );

  lgr_lane_path #(
    .NUM_LINKS (NUM_LINKS)
  ) u_lane_path (
    .tx_cfg        (tx_cfg),
    .rx_cfg        (rx_cfg),
    .lane_off      (lane_off),
    .pin_rxd       (pin_rxd),
    .pin_rxclk     (pin_rxclk),
    .pin_rxsync    (pin_rxsync),
    .core_txd      (core_txd),
    .core_txclk    (core_txclk),
    .core_txsync   (core_txsync),
    .pin_txd       (pin_txd),
    .pin_txclk     (pin_txclk),
    .pin_txsync    (pin_txsync),
    .pin_txd_oe    (pin_txd_oe),
    .pin_txclk_oe  (pin_txclk_oe),
    .pin_txsync_oe (pin_txsync_oe),
    .core_rxd      (core_rxd),
    .core_rxclk    (core_rxclk),
    .core_rxsync   (core_rxsync)
  );

  // Group-level checks relating the decoded words to the pin enables
  for (genvar g = 0; g < NUM_LINKS / GROUP_SIZE; g++) begin : g_grp_chk
    localparam int BASE = g * GROUP_SIZE;

    assert_survivor_live_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      pin_txd_oe[BASE]);

    for (genvar k = 1; k < GROUP_SIZE; k++) begin : g_mem_chk
      assert_member_quiet_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (tx_cfg[BASE].fast || rx_cfg[BASE].fast) |->
          !pin_txd_oe[BASE+k] && !pin_txclk_oe[BASE+k] && !pin_txsync_oe[BASE+k] &&
          !core_rxd[BASE+k] && !pin_txd[BASE+k]);
    end
  end

  // Per-link loopback checks on the port values
  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane_chk
    assert_remote_reflect_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (tx_cfg[i].loop && !lane_off[i]) |->
        (pin_txd[i] == pin_rxd[i]) && (pin_txsync[i] == pin_rxsync[i]) && pin_txclk_oe[i]);

    assert_metallic_feed_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rx_cfg[i].loop && !lane_off[i]) |->
        (core_rxd[i] == core_txd[i]) && (core_rxsync[i] == core_txsync[i]));

    assert_direct_path_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!tx_cfg[i].loop && !rx_cfg[i].loop && !lane_off[i]) |->
        (pin_txd[i] == core_txd[i]) && (core_rxd[i] == pin_rxd[i]) && pin_txd_oe[i]);
  end

endmodule

// File: tb/lgr_top_bench.sv
module lgr_top_bench;

  localparam int N  = 16;
  localparam int GS = 4;
  localparam int W  = 16;

  logic clk;
  logic rst_n;
  logic [N*W-1:0] tx_ctrl, rx_ctrl;
  logic [N-1:0] pin_rxd, pin_rxclk, pin_rxsync, core_txd, core_txclk, core_txsync;
  logic [N-1:0] pin_txd, pin_txclk, pin_txsync, pin_txd_oe, pin_txclk_oe, pin_txsync_oe;
  logic [N-1:0] core_rxd, core_rxclk, core_rxsync;

  logic [W-1:0] txw [N];
  logic [W-1:0] rxw [N];
  logic [W-1:0] m_tx [N];
  logic [W-1:0] m_rx [N];
  bit   m_r1, m_r2;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit run_cmp = 0;

  lgr_top #(.NUM_LINKS(N), .GROUP_SIZE(GS), .CW_W(W)) u_lgr_top (
    .clk(clk), .rst_n(rst_n), .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl),
    .pin_rxd(pin_rxd), .pin_rxclk(pin_rxclk), .pin_rxsync(pin_rxsync),
    .core_txd(core_txd), .core_txclk(core_txclk), .core_txsync(core_txsync),
    .pin_txd(pin_txd), .pin_txclk(pin_txclk), .pin_txsync(pin_txsync),
    .pin_txd_oe(pin_txd_oe), .pin_txclk_oe(pin_txclk_oe), .pin_txsync_oe(pin_txsync_oe),
    .core_rxd(core_rxd), .core_rxclk(core_rxclk), .core_rxsync(core_rxsync)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tx_ctrl[i*W +: W] = txw[i];
      rx_ctrl[i*W +: W] = rxw[i];
    end
  end

  // Reference: words take effect two edges after reset release, then each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 0; m_r2 <= 0;
      for (int i = 0; i < N; i++) begin m_tx[i] <= '0; m_rx[i] <= '0; end
    end else begin
      m_r1 <= 1; m_r2 <= m_r1;
      for (int i = 0; i < N; i++) begin
        m_tx[i] <= m_r2 ? txw[i] : '0;
        m_rx[i] <= m_r2 ? rxw[i] : '0;
      end
    end
  end

  function automatic bit pat_ok(logic [W-1:0] w);
    return (w[6:5] == 2'b11) && (w[4:3] == 2'b00) && (w[2] == 1'b0);
  endfunction

  function automatic bit m_off(int i);
    int s = (i / GS) * GS;
    if (i == s) return 0;
    return pat_ok(m_tx[s]) || (pat_ok(m_rx[s]) && m_rx[s][10]);
  endfunction

  task automatic fail_line(string req, string what, int lane, int act, int exp);
    fails++;
    $display("FAIL %s %s link %0d actual=%0d expected=%0d", req, what, lane, act, exp);
  endtask

  task automatic cmp_all();
    bit bad = 0;
    for (int i = 0; i < N; i++) begin
      bit off = m_off(i);
      bit rl = m_tx[i][8];
      bit ml = m_rx[i][8];
      bit cs = !off && (m_tx[i][7] || rl);
      logic [2:0] e_ptx, e_crx, e_oe, a_ptx, a_crx, a_oe;
      string rq_t, rq_r, rq_o;
      e_ptx = off ? 3'b0 : (rl ? {pin_rxd[i], pin_rxclk[i], pin_rxsync[i]}
                               : {core_txd[i], core_txclk[i], core_txsync[i]});
      e_crx = off ? 3'b0 : (ml ? {core_txd[i], core_txclk[i], core_txsync[i]}
                               : {pin_rxd[i], pin_rxclk[i], pin_rxsync[i]});
      e_oe  = {!off, cs, cs};
      a_ptx = {pin_txd[i], pin_txclk[i], pin_txsync[i]};
      a_crx = {core_rxd[i], core_rxclk[i], core_rxsync[i]};
      a_oe  = {pin_txd_oe[i], pin_txclk_oe[i], pin_txsync_oe[i]};
      rq_t = off ? "R5" : (rl ? (ml ? "R9" : "R7") : "R10");
      rq_r = off ? "R5" : (ml ? (rl ? "R9" : "R8") : "R7");
      rq_o = off ? "R5" : "R10";
      if (a_ptx !== e_ptx) begin fail_line(rq_t, "pin_tx", i, a_ptx, e_ptx); bad = 1; end
      if (a_crx !== e_crx) begin fail_line(rq_r, "core_rx", i, a_crx, e_crx); bad = 1; end
      if (a_oe  !== e_oe ) begin fail_line(rq_o, "oe", i, a_oe, e_oe); bad = 1; end
    end
    checks++;
    if (bad) $display("  (cycle compare above counted as one check)");
  endtask

  // Drive data at each falling edge, compare with the reference shortly after
  always @(negedge clk) begin
    pin_rxd <= $urandom; pin_rxclk <= $urandom; pin_rxsync <= $urandom;
    core_txd <= $urandom; core_txclk <= $urandom; core_txsync <= $urandom;
    #1;
    if (run_cmp && !finished) cmp_all();
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_words();
    for (int i = 0; i < N; i++) begin txw[i] = '0; rxw[i] = '0; end
  endtask

  // Change words just after a falling edge; check just before the next edge
  task automatic settle();
    @(posedge clk); @(negedge clk); #2;
  endtask

  function automatic logic [W-1:0] pick_word();
    case ($urandom_range(0, 9))
      0: return 16'h0060;
      1: return 16'h0460;
      2: return 16'h0100;
      3: return 16'h0080;
      4: return 16'h0180;
      5: return 16'h0064;
      6: return 16'h0068;
      7: return 16'h0560;
      8: return 16'h0000;
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    rst_n = 0;
    clear_words();
    txw[3] = 16'h0180;
    pin_rxd = '0; pin_rxclk = '0; pin_rxsync = '0;
    core_txd = '0; core_txclk = '0; core_txsync = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    // R11: reset forces zero words: all live, no clock/sync drive
    chk("R11", "data oe during reset", pin_txd_oe, 16'hFFFF);
    chk("R11", "clk oe during reset", pin_txclk_oe, 0);
    run_cmp = 1;
    rst_n = 1;
    @(posedge clk); @(negedge clk); #2;
    chk("R11", "clk oe one edge after release", pin_txclk_oe[3], 0);
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    chk("R10", "clk oe from drive bit", pin_txclk_oe[3], 1);
    clear_words();

    // R1: new word is not seen before the next edge
    settle();
    @(negedge clk);
    txw[0] = 16'h0060;
    #2;
    chk("R1", "before edge link1 oe", pin_txd_oe[1], 1);
    @(posedge clk); @(negedge clk); #2;
    chk("R1", "after edge link1 oe", pin_txd_oe[1], 0);
    chk("R3", "tx high-rate shuts link3", pin_txsync_oe[3] | pin_txd_oe[3], 0);
    chk("R2", "survivor 0 live", pin_txd_oe[0], 1);

    // R3 near misses on survivor 4
    @(negedge clk); clear_words(); txw[4] = 16'h0064; settle();
    chk("R3", "format bit set no effect", pin_txd_oe[5], 1);
    @(negedge clk); txw[4] = 16'h0068; settle();
    chk("R3", "multiplex field set no effect", pin_txd_oe[6], 1);
    @(negedge clk); txw[4] = 16'h0040; settle();
    chk("R3", "rate field 10 no effect", pin_txd_oe[7], 1);

    // R4: receive word needs bit 10
    @(negedge clk); clear_words(); rxw[8] = 16'h0060; settle();
    chk("R4", "rx without bit10 no effect", pin_txd_oe[9], 1);
    @(negedge clk); rxw[8] = 16'h0460; settle();
    chk("R4", "rx with bit10 shuts link9", pin_txd_oe[9], 0);
    chk("R5", "shut link core rx low", core_rxd[10] | core_rxclk[10], 0);

    // R6: high-rate word on a non-survivor
    @(negedge clk); clear_words(); txw[13] = 16'h0060; rxw[14] = 16'h0460; settle();
    chk("R6", "non-survivor word no effect", pin_txd_oe[15:12], 4'hF);
    @(negedge clk); txw[12] = 16'h0060; txw[14] = 16'h0100; settle();
    chk("R2", "survivor 12 live in high-rate", pin_txd_oe[12], 1);
    chk("R5", "loopback on shut link still off", pin_txclk_oe[14], 0);

    // R7, R8, R9 directed on link 2
    @(negedge clk); clear_words(); txw[2] = 16'h0100; settle();
    chk("R7", "remote sync oe", pin_txsync_oe[2], 1);
    chk("R7", "remote data", pin_txd[2], pin_rxd[2]);
    @(negedge clk); txw[2] = 16'h0000; rxw[2] = 16'h0100; settle();
    chk("R8", "metallic clock", core_rxclk[2], core_txclk[2]);
    @(negedge clk); txw[2] = 16'h0100; settle();
    chk("R9", "both: pins", pin_txsync[2], pin_rxsync[2]);
    chk("R9", "both: core", core_rxd[2], core_txd[2]);

    // Random phase, every cycle compared against the reference
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        for (int k = 0; k < 3; k++) begin
          int l = $urandom_range(0, N - 1);
          if ($urandom_range(0, 1) == 1) txw[l] = pick_word();
          else rxw[l] = pick_word();
        end
      end
      if ($urandom_range(0, 150) == 0) clear_words();
    end
    @(negedge clk); #3;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule